// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block lets any of up to eight processors raise software-generated interrupts (SGIs) towards other processors and tracks them. There are 16 SGI numbers. For every (target processor, SGI number) pair the block keeps a mask with one bit per processor that raised that SGI. The pair is pending whenever its mask is non-zero. All pending bits are exported as one flat vector, so a downstream interrupt arbiter can consume them.

Processors reach the block through a simple single-cycle register port. Every access carries the issuing processor's number. The port has three windows:
- a write-only generation register, which raises one SGI at a set of targets chosen by a filter mode;
- a set window, which adds source bits to the caller's own masks;
- a clear window, which removes source bits from the caller's own masks.

The set and clear windows accept byte accesses and word accesses. In both, each byte lane holds the mask of one SGI. Read data is combinational and is valid in the same cycle as the request.

Top module: `sgi_dispatch`

## Requirements
- R1: Reset (`rst_n` low) clears every source mask, so all bits of `sgi_pend` read zero after reset.
- R2: Address bits [5:4] choose the window: 0 is the generation register, 1 is the clear window, 2 is the set window. A generation write takes the SGI number from data [3:0], the target list from data [23:16] (bit 16+c selects processor c) and the filter mode from data [25:24]. In mode 0 every listed processor gets the writer's bit ORed into its mask for that SGI. `sgi_pend[c*16+s]` is the OR of processor c's mask for SGI s.
- R3: Filter mode 1 targets every online processor except the writer, whatever the target list holds.
- R4: Filter mode 2 targets only the writer, whatever the target list holds.
- R5: A generation write with filter mode 3 changes no state.
- R6: A processor whose number is at or above `online_cnt` is never made a target, in any mode.
- R7: Reads in the generation window return zero.
- R8: A set-window write ORs each written byte into the matching mask of the accessing processor. It leaves the masks of all other processors alone.
- R9: A clear-window write removes the written bits from the accessing processor's masks. A pending bit drops only when its mask becomes all-zero, and nothing other than a clear-window write makes it drop.
- R10: In a word access (`bus_wide`=1), byte lane k (data bits [8k+7:8k]) maps to SGI 4*addr[3:2]+k, and addr[1:0] is ignored. In a byte access (`bus_wide`=0), data bits [7:0] map to SGI addr[3:0].
- R11: Reads in either bank window return the accessing processor's masks, using the lane mapping of R10. A byte read returns zero in bits [31:8].
- R12: Address window 3 is reserved. Reads there return zero and writes there change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| online_cnt | input | 4 | Number of online processors (0 to 8) |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 8-bit access |
| bus_cpu | input | 3 | Number of the processor issuing the access |
| bus_addr | input | 6 | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| sgi_pend | output | 128 | Pending bit for processor c and SGI s at index c*16+s |

## Verification
Several properties are checked on every cycle:
- all pending bits read zero right after reset;
- reads in the generation window and in the reserved window return zero, and byte reads return zero above bit 7;
- mode-3 generation writes and reserved-window writes leave the pending vector unchanged;
- no pending bit ever falls except after a clear-window write;
- a set-window write never changes another processor's pending bits.

Only the bench scenarios can show the following, because the mask contents have to be compared against a bench-side model:
- that the filter modes pick the right targets for every writer and for several online counts;
- that the lane mapping places each byte on the right SGI;
- that a partial clear keeps an SGI pending while other sources remain.

// File: rtl/sgi_dispatch.sv
module sgi_dispatch #(
  parameter int NCPU = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [3:0]              online_cnt,
  input  logic                    bus_en,
  input  logic                    bus_we,
  input  logic                    bus_wide,
  input  logic [2:0]              bus_cpu,
  input  logic [5:0]              bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic [NCPU*16-1:0]      sgi_pend
);
  localparam int NSGI = 16;
  localparam int OW   = 4;

  logic [NCPU-1:0][NSGI-1:0][NCPU-1:0] src_q, src_d;
  logic [NCPU-1:0] onl, self, tgt;
  logic [NSGI-1:0] lane_hit;
  logic [NSGI-1:0][NCPU-1:0] lane_dat;

  wire [1:0] win    = bus_addr[5:4];
  wire       gen_wr = bus_en && bus_we && win == 2'd0;
  wire       clr_wr = bus_en && bus_we && win == 2'd1;
  wire       set_wr = bus_en && bus_we && win == 2'd2;
  wire [1:0] mode   = bus_wdata[25:24];
  wire [3:0] gsgi   = bus_wdata[3:0];

  assign self = NCPU'(1) << bus_cpu;

  always_comb begin
    for (int c = 0; c < NCPU; c++) onl[c] = OW'(c) < online_cnt;
    case (mode)
      2'd0:    tgt = bus_wdata[16 +: NCPU];
      2'd1:    tgt = ~self;
      2'd2:    tgt = self;
      default: tgt = '0;
    endcase
    tgt = tgt & onl;
  end

  always_comb begin
    for (int s = 0; s < NSGI; s++) begin
      if (bus_wide) begin
        lane_hit[s] = 2'(s / 4) == bus_addr[3:2];
        lane_dat[s] = bus_wdata[8*(s%4) +: NCPU];
      end else begin
        lane_hit[s] = 4'(s) == bus_addr[3:0];
        lane_dat[s] = bus_wdata[NCPU-1:0];
      end
    end
  end

  always_comb begin
    src_d = src_q;
    for (int c = 0; c < NCPU; c++) begin
      for (int s = 0; s < NSGI; s++) begin
        if (gen_wr && tgt[c] && gsgi == 4'(s))
          src_d[c][s] = src_d[c][s] | self;
        if (3'(c) == bus_cpu && lane_hit[s]) begin
          if (set_wr) src_d[c][s] = src_d[c][s] | lane_dat[s];
          if (clr_wr) src_d[c][s] = src_d[c][s] & ~lane_dat[s];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_d;
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    for (genvar s = 0; s < NSGI; s++) begin : g_sgi
      assign sgi_pend[c*NSGI+s] = |src_q[c][s];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (win == 2'd1 || win == 2'd2) begin
      if (bus_wide) begin
        for (int k = 0; k < 4; k++)
          bus_rdata[8*k +: NCPU] = src_q[bus_cpu][{bus_addr[3:2], 2'(k)}];
      end else begin
        bus_rdata[NCPU-1:0] = src_q[bus_cpu][bus_addr[3:0]];
      end
    end
  end
endmodule

module sgi_dispatch_chk #(
  parameter int NCPU = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_en,
  input logic               bus_we,
  input logic               bus_wide,
  input logic [2:0]         bus_cpu,
  input logic [5:0]         bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic [NCPU*16-1:0] sgi_pend
);
  logic [NCPU*16-1:0] own_sel;
  always_comb begin
    own_sel = '0;
    for (int c = 0; c < NCPU; c++)
      if (3'(c) == bus_cpu) own_sel[c*16 +: 16] = '1;
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> sgi_pend == '0);

  p_gen_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr[5:4] == 2'd0) |-> bus_rdata == '0);

  p_mode3_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr[5:4] == 2'd0 && bus_wdata[25:24] == 2'd3)
    |=> $stable(sgi_pend));

  p_reserved_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr[5:4] == 2'd3) |=> $stable(sgi_pend));

  p_reserved_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr[5:4] == 2'd3) |-> bus_rdata == '0);

  p_no_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && bus_we && bus_addr[5:4] == 2'd1)
    |=> (($past(sgi_pend) & ~sgi_pend) == '0));

  p_set_own_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr[5:4] == 2'd2)
    |=> (((sgi_pend ^ $past(sgi_pend)) & ~$past(own_sel)) == '0));

  p_byte_read_upper_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && !bus_wide && (bus_addr[5:4] == 2'd1 || bus_addr[5:4] == 2'd2))
    |-> bus_rdata[31:8] == '0);
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NCPU(NCPU)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_wide(bus_wide), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sgi_pend(sgi_pend)
);

// File: tb/sgi_dispatch_tb.sv
module sgi_dispatch_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   online_cnt = 4'd8;
  logic         bus_en = 1'b0, bus_we = 1'b0, bus_wide = 1'b0;
  logic [2:0]   bus_cpu = '0;
  logic [5:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] sgi_pend;

  int n_chk = 0, n_fail = 0;
  logic [7:0] model [8][16];

  always #10 clk = ~clk;

  sgi_dispatch #(.NCPU(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .online_cnt(online_cnt), .bus_en(bus_en),
    .bus_we(bus_we), .bus_wide(bus_wide), .bus_cpu(bus_cpu),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sgi_pend(sgi_pend)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_pend();
    logic [127:0] e = '0;
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 16; s++) e[c*16+s] = model[c][s] != 8'd0;
    return e;
  endfunction

  task automatic wr(input int cpu, input logic [5:0] a, input bit wide, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_cpu = 3'(cpu); bus_addr = a; bus_wide = wide; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input int cpu, input logic [5:0] a, input bit wide, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_cpu = 3'(cpu); bus_addr = a; bus_wide = wide;
    #2 d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic gen(input int src, input int mode, input logic [7:0] tl, input int sgi);
    logic [31:0] d = {6'd0, 2'(mode), tl, 12'd0, 4'(sgi)};
    wr(src, 6'h00, 1, d);
    for (int c = 0; c < 8; c++) begin
      bit t;
      case (mode)
        0: t = tl[c];
        1: t = (c != src);
        2: t = (c == src);
        default: t = 0;
      endcase
      if (t && c < int'(online_cnt)) model[c][sgi] |= 8'(1 << src);
    end
  endtask

  task automatic bank(input int src, input logic [5:0] a, input bit wide, input logic [31:0] d);
    wr(src, a, wide, d);
    if (a[5:4] == 2'd1 || a[5:4] == 2'd2) begin
      for (int k = 0; k < 4; k++) begin
        int s;
        logic [7:0] b;
        if (!wide && k > 0) break;
        s = wide ? int'(a[3:2]) * 4 + k : int'(a[3:0]);
        b = wide ? d[8*k +: 8] : d[7:0];
        if (a[5:4] == 2'd2) model[src][s] |= b;
        else model[src][s] &= ~b;
      end
    end
  endtask

  task automatic check_state(input string tag, input logic [5:0] base);
    logic [31:0] r;
    chk(tag, sgi_pend, exp_pend());
    for (int c = 0; c < 8; c++)
      for (int w = 0; w < 4; w++) begin
        rd(c, base + 6'(4*w), 1, r);
        chk("R11 word readback", 128'(r),
            128'({model[c][4*w+3], model[c][4*w+2], model[c][4*w+1], model[c][4*w]}));
      end
  endtask

  task automatic clear_all();
    for (int c = 0; c < 8; c++)
      for (int w = 0; w < 4; w++) bank(c, 6'h10 + 6'(4*w), 1, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    for (int c = 0; c < 8; c++) for (int s = 0; s < 16; s++) model[c][s] = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset pending", sgi_pend, 128'd0);
    check_state("R1 reset masks", 6'h20);
    rd(3, 6'h04, 1, r);
    chk("R7 generation read", 128'(r), 128'd0);

    for (int src = 0; src < 8; src++) begin
      gen(src, 0, 8'hA5 ^ 8'(src * 37), src);
      gen(src, 0, 8'(1 << src) | 8'h10, 15 - src);
      chk("R2 mode0 targets", sgi_pend, exp_pend());
    end
    check_state("R2 mode0 state", 6'h10);
    clear_all();
    check_state("R9 clear all", 6'h20);

    for (int oi = 0; oi < 3; oi++) begin
      online_cnt = (oi == 0) ? 4'd8 : (oi == 1) ? 4'd5 : 4'd1;
      for (int src = 0; src < int'(online_cnt); src++) begin
        gen(src, 1, 8'h00, (src * 3) % 16);
        chk("R3 mode1 all but self", sgi_pend, exp_pend());
        gen(src, 2, 8'hFF, (src * 5 + 1) % 16);
        chk("R4 mode2 self only", sgi_pend, exp_pend());
      end
      gen(1, 0, 8'hFF, 7);
      chk("R6 targets above online ignored", sgi_pend, exp_pend());
      check_state("R6 state", 6'h10);
      clear_all();
    end
    online_cnt = 4'd8;

    gen(2, 0, 8'h0F, 9);
    for (int src = 0; src < 8; src++) begin
      gen(src, 3, 8'hFF, src);
      chk("R5 mode3 dropped", sgi_pend, exp_pend());
    end
    check_state("R5 state", 6'h10);

    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 16; s += 3) begin
        bank(c, 6'h20 + 6'(s), 0, 32'hFFFF_FF00 | 32'(8'(c * 17 + s + 1)));
        rd(c, 6'h10 + 6'(s), 0, r);
        chk("R10 byte lane readback", 128'(r), 128'(model[c][s]));
      end
    chk("R8 set bank pending", sgi_pend, exp_pend());
    check_state("R8 set state", 6'h20);
    clear_all();

    bank(4, 6'h26, 0, 32'h0000_0014);
    chk("R8 set byte", sgi_pend, exp_pend());
    bank(4, 6'h16, 0, 32'h0000_0004);
    chk("R9 partial clear keeps pending", 128'(sgi_pend[4*16+6]), 128'd1);
    bank(4, 6'h16, 0, 32'h0000_0010);
    chk("R9 last clear drops pending", 128'(sgi_pend[4*16+6]), 128'd0);

    bank(6, 6'h29, 1, 32'h8040_2001);
    chk("R10 word lanes", sgi_pend, exp_pend());
    rd(6, 6'h2A, 0, r);
    chk("R10 byte read of word-written lane", 128'(r), 128'h40);
    check_state("R10 word state", 6'h20);

    bank(0, 6'h30, 1, 32'hFFFF_FFFF);
    bank(0, 6'h3C, 0, 32'hFFFF_FFFF);
    chk("R12 reserved write ignored", sgi_pend, exp_pend());
    rd(6, 6'h38, 1, r);
    chk("R12 reserved read zero", 128'(r), 128'd0);
    check_state("R12 state", 6'h10);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule